// File: doc/BRIEF.md
# Bulk Erase Sequencer

This block is the host-side controller for a bulk-erasable byte memory. It runs the whole closed-loop chip erase without software help. After a start request it enables the high programming voltage and writes the erase command byte twice. It then waits for the erase pulse to finish and checks the array one byte at a time. For each byte it writes the erase-verify command together with the byte address, waits for the verify settle time, reads the byte back, and expects all ones. The array is not preprogrammed before erasing.

When a byte still holds a zero bit, the sequencer erases the whole array again. Verification then restarts at the byte that failed, because all earlier bytes have already passed. A single pulse budget is shared by the whole chip, not kept per byte. Once the last address passes, or the budget is spent, the sequencer writes the read-mode command and drops the high-voltage enable. In the same cycle it pulses either `done` or `err`. The erase pulse time and the verify settle time are parameters given in clock cycles.

Top module: `bulk_erase_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `hv_en`, `bus_wr`, `bus_rd`, `done` and `err` are all low.
- R2: `hv_en` rises one cycle before the first bus write of an operation and stays high for every bus write and read of that operation. It is low in the cycle where `done` or `err` is high.
- R3: Every erase pulse is started by two bus writes of command 0x20 on consecutive cycles. The first write of an operation is 0x20, so no program pass comes before the erase.
- R4: After the second 0x20 write, the bus stays quiet for exactly `ERASE_CYCLES` cycles. The next command comes ERASE_CYCLES+1 cycles after that write.
- R5: A verify step is a bus write of command 0xA0 with the byte address on `bus_addr`. Exactly VERIFY_WAIT_CYCLES+1 cycles later comes a one-cycle `bus_rd` at the same address. `rd_data` is sampled in the cycle after `bus_rd`.
- R6: In the first pass, verification starts at address 0. After a byte reads 0xFF, the next verify goes to the next address, up to `LAST_ADDR`.
- R7: A byte that does not read 0xFF triggers a new erase pulse (R3) if the budget allows. The first verify after that pulse uses the failing address.
- R8: At most `MAX_PULSES` erase pulses are issued per operation. A failed byte after the last allowed pulse ends the operation with `err`.
- R9: An operation always ends with a bus write of command 0x00. In the next cycle `hv_en` is low and exactly one of `done` or `err` pulses: `done` when every byte passed, `err` when the budget ran out.
- R10: `done` and `err` are single-cycle pulses. `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a chip erase (sampled only when idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: array erased |
| err | output | 1 | One-cycle pulse: pulse budget exhausted |
| hv_en | output | 1 | Enable for the high programming voltage |
| bus_wr | output | 1 | Command write strobe |
| bus_rd | output | 1 | Verify read strobe |
| bus_cmd | output | 8 | Command byte, valid with bus_wr |
| bus_addr | output | ADDR_W | Byte address for verify write and read |
| rd_data | input | 8 | Read data, valid the cycle after bus_rd |

## Verification
The bench sweeps one slow byte across every address of a small array, with every pulse count from one up to one past the budget. It also runs a pattern with several slow bytes. If verification restarted at zero after a re-erase, the bench would see extra reads and a wrong resume address. A per-byte budget would let the error case run past `MAX_PULSES`. An off-by-one in either wait would move the verify command or the read by a cycle. A misplaced end pulse, a missing 0x00 write, or a start request accepted while busy would show up as the wrong number of bus writes or end pulses.

// File: rtl/erase_seq_pkg.sv
// Package: shared command codes and sequencer state encoding.
// Assumes an 8-bit command bus on the memory side.
package erase_seq_pkg;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] BYTE_BLANK = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HV_UP,
        ST_SETUP,
        ST_ERASE,
        ST_PULSE,
        ST_VCMD,
        ST_VWAIT,
        ST_VREAD,
        ST_VCHK,
        ST_CLOSE,
        ST_END
    } seq_state_t;

endpackage

// File: rtl/erase_cycle_timer.sv
// Module: loadable down-counter shared by the erase-pulse wait and the
// verify settle wait. Loading N-1 gives a wait state of exactly N cycles
// that ends on the cycle where 'expired' is high.
// Assumes the controller loads it only in a cycle with a bus strobe.
module erase_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Count down to zero after a load; hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // Requirement R4/R5: the wait shortens by one each idle cycle.
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/erase_verify_tracker.sv
// Module: holds the verify address and the chip-wide erase pulse count.
// The address is not rewound on a re-erase, so verification resumes at
// the byte that failed. Assumes LAST_ADDR fits in AW bits.
module erase_verify_tracker #(
    parameter int AW         = 17,
    parameter int LAST_ADDR  = 131071,
    parameter int MAX_PULSES = 30,
    parameter int PW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          addr_inc,
    input  logic          pulse_inc,
    output logic [AW-1:0] addr,
    output logic          at_last,
    output logic          budget_spent
);

    logic [AW-1:0] addr_q;
    logic [PW-1:0] pls_q;

    // Verify address: cleared at start, stepped after a passing byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            addr_q <= '0;
        else if (addr_inc)
            addr_q <= addr_q + 1'b1;
    end

    // Pulse count: cleared at start, bumped on each erase pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pls_q <= '0;
        else if (pulse_inc)
            pls_q <= pls_q + 1'b1;
    end

    assign addr         = addr_q;
    assign at_last      = (addr_q == AW'(LAST_ADDR));
    assign budget_spent = (pls_q == PW'(MAX_PULSES));

    // Requirement R8: the pulse budget is never exceeded.
    assert_budget_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pls_q <= PW'(MAX_PULSES));

    // Requirement R7: a re-erase leaves the verify address untouched.
    assert_resume_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !addr_inc) |=> $stable(addr_q));

    // Requirement R6: a passing byte steps the address by exactly one.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_inc && !clr) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/erase_seq_ctrl.sv
// Module: state machine for the closed-loop erase algorithm.
// Assumes read data returns one cycle after bus_rd, and that the timer
// flags expiry in the last cycle of each wait.
module erase_seq_ctrl
    import erase_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] rd_data,
    input  logic       tmr_expired,
    input  logic       at_last,
    input  logic       budget_spent,
    output logic       tmr_load,
    output logic       tmr_sel_verify,
    output logic       trk_clr,
    output logic       trk_addr_inc,
    output logic       trk_pulse_inc,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic       hv_en,
    output logic       bus_wr,
    output logic       bus_rd,
    output logic [7:0] bus_cmd
);

    seq_state_t state_q, state_d;
    logic       ok_q, ok_d;

    // State and outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ok_q    <= ok_d;
        end
    end

    // Next state, outcome and tracker controls.
    always_comb begin
        state_d       = state_q;
        ok_d          = ok_q;
        trk_clr       = 1'b0;
        trk_addr_inc  = 1'b0;
        trk_pulse_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    trk_clr = 1'b1;
                    ok_d    = 1'b0;
                    state_d = ST_HV_UP;
                end
            end
            ST_HV_UP:  state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ERASE;
            ST_ERASE: begin
                trk_pulse_inc = 1'b1;
                state_d       = ST_PULSE;
            end
            ST_PULSE:  if (tmr_expired) state_d = ST_VCMD;
            ST_VCMD:   state_d = ST_VWAIT;
            ST_VWAIT:  if (tmr_expired) state_d = ST_VREAD;
            ST_VREAD:  state_d = ST_VCHK;
            ST_VCHK: begin
                if (rd_data == BYTE_BLANK) begin
                    if (at_last) begin
                        ok_d    = 1'b1;
                        state_d = ST_CLOSE;
                    end else begin
                        trk_addr_inc = 1'b1;
                        state_d      = ST_VCMD;
                    end
                end else if (budget_spent) begin
                    ok_d    = 1'b0;
                    state_d = ST_CLOSE;
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_CLOSE:  state_d = ST_END;
            ST_END:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Bus strobes, command byte and timer loads decoded from state.
    always_comb begin
        bus_wr         = 1'b0;
        bus_rd         = 1'b0;
        bus_cmd        = CMD_READ;
        tmr_load       = 1'b0;
        tmr_sel_verify = 1'b0;
        unique case (state_q)
            ST_SETUP: begin
                bus_wr  = 1'b1;
                bus_cmd = CMD_ERASE;
            end
            ST_ERASE: begin
                bus_wr   = 1'b1;
                bus_cmd  = CMD_ERASE;
                tmr_load = 1'b1;
            end
            ST_VCMD: begin
                bus_wr         = 1'b1;
                bus_cmd        = CMD_VERIFY;
                tmr_load       = 1'b1;
                tmr_sel_verify = 1'b1;
            end
            ST_VREAD:  bus_rd = 1'b1;
            ST_CLOSE: begin
                bus_wr  = 1'b1;
                bus_cmd = CMD_READ;
            end
            default: ;
        endcase
    end

    assign busy  = (state_q != ST_IDLE);
    assign hv_en = (state_q != ST_IDLE) && (state_q != ST_END);
    assign done  = (state_q == ST_END) && ok_q;
    assign err   = (state_q == ST_END) && !ok_q;

    // Requirement R2: no bus access without the high voltage enabled.
    assert_strobe_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> hv_en);

    // Requirement R3: a lone first 0x20 write is followed by a second one.
    assert_erase_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_cmd == CMD_ERASE &&
         !($past(bus_wr) && $past(bus_cmd) == CMD_ERASE))
        |=> (bus_wr && bus_cmd == CMD_ERASE));

    // Requirement R9: the end pulse follows the read-mode write, voltage off.
    assert_close_then_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> ($past(bus_wr) && $past(bus_cmd) == CMD_READ && !hv_en));

    // Requirement R10: end pulses last one cycle and never coincide.
    assert_end_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));
    assert_end_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

// File: rtl/bulk_erase_seq.sv
// Module: top of the bulk erase and verify sequencer. It connects the
// controller, the shared wait timer and the address/budget tracker.
// Assumes ERASE_CYCLES and VERIFY_WAIT_CYCLES are at least 1.
module bulk_erase_seq #(
    parameter int ADDR_W             = 17,
    parameter int LAST_ADDR          = (1 << ADDR_W) - 1,
    parameter int ERASE_CYCLES       = 20000000,
    parameter int VERIFY_WAIT_CYCLES = 1200,
    parameter int MAX_PULSES         = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              hv_en,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [7:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        rd_data
);

    localparam int LONGEST = (ERASE_CYCLES > VERIFY_WAIT_CYCLES) ?
                             ERASE_CYCLES : VERIFY_WAIT_CYCLES;
    localparam int TW = $clog2(LONGEST + 1);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] ERASE_LOAD  = TW'(ERASE_CYCLES - 1);
    localparam logic [TW-1:0] VERIFY_LOAD = TW'(VERIFY_WAIT_CYCLES - 1);

    logic          tmr_load, tmr_sel_verify, tmr_expired;
    logic          trk_clr, trk_addr_inc, trk_pulse_inc;
    logic          at_last, budget_spent;
    logic [TW-1:0] tmr_val;

    assign tmr_val = tmr_sel_verify ? VERIFY_LOAD : ERASE_LOAD;

    erase_seq_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .rd_data        (rd_data),
        .tmr_expired    (tmr_expired),
        .at_last        (at_last),
        .budget_spent   (budget_spent),
        .tmr_load       (tmr_load),
        .tmr_sel_verify (tmr_sel_verify),
        .trk_clr        (trk_clr),
        .trk_addr_inc   (trk_addr_inc),
        .trk_pulse_inc  (trk_pulse_inc),
        .busy           (busy),
        .done           (done),
        .err            (err),
        .hv_en          (hv_en),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_cmd        (bus_cmd)
    );

    erase_cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    erase_verify_tracker #(
        .AW         (ADDR_W),
        .LAST_ADDR  (LAST_ADDR),
        .MAX_PULSES (MAX_PULSES),
        .PW         (PW)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (trk_clr),
        .addr_inc     (trk_addr_inc),
        .pulse_inc    (trk_pulse_inc),
        .addr         (bus_addr),
        .at_last      (at_last),
        .budget_spent (budget_spent)
    );

endmodule

// File: tb/sim_bulk_erase_seq.sv
// Bench: sweeps a slow-to-erase byte over every address and pulse count
// of an 8-byte array; a behavioural memory answers verify reads.
module sim_bulk_erase_seq;

    localparam int AW    = 3;
    localparam int DEPTH = 8;
    localparam int ECYC  = 5;
    localparam int VCYC  = 3;
    localparam int MAXP  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, err, hv_en, bus_wr, bus_rd;
    logic [7:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [7:0]    rd_data = 8'h00;

    always #2.5 clk = ~clk;

    bulk_erase_seq #(
        .ADDR_W(AW), .LAST_ADDR(DEPTH - 1), .ERASE_CYCLES(ECYC),
        .VERIFY_WAIT_CYCLES(VCYC), .MAX_PULSES(MAXP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .err(err), .hv_en(hv_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .rd_data(rd_data)
    );

    int n_chk = 0, n_bad = 0;
    int need [DEPTH];
    int cyc = 0, erases, nwr, nrd, n_close, n_end, got_err;
    int have20, w20_cyc, pair_cyc, after_pair, a0_seen, a0_cyc, a0_addr;
    int resume, fail_addr, prev, close_cyc;
    int v_hv, v_r3, v_r4, v_r5, v_r6, v_r7, v_r9;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        erases = 0; nwr = 0; nrd = 0; n_close = 0; n_end = 0; got_err = 0;
        have20 = 0; w20_cyc = 0; pair_cyc = 0; after_pair = 0; a0_seen = 0;
        a0_cyc = 0; a0_addr = 0; resume = 0; fail_addr = 0; prev = 0;
        close_cyc = -10;
        v_hv = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r7 = 0; v_r9 = 0;
    endtask

    // Bus monitor and memory model; runs on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (bus_wr) begin
            if (!hv_en) v_hv++;
            if (nwr == 0 && bus_cmd != 8'h20) v_r3++;
            if (bus_cmd == 8'h20) begin
                if (have20 != 0 && w20_cyc == cyc - 1) begin
                    erases++; have20 = 0; pair_cyc = cyc;
                    after_pair = 1; resume = 1;
                end else begin
                    if (have20 != 0) v_r3++;
                    have20 = 1; w20_cyc = cyc;
                end
            end else begin
                if (have20 != 0) v_r3++;
                have20 = 0;
                if (bus_cmd == 8'hA0) begin
                    if (after_pair != 0 && cyc != pair_cyc + ECYC + 1) v_r4++;
                    after_pair = 0; a0_seen = 1; a0_cyc = cyc; a0_addr = int'(bus_addr);
                end else if (bus_cmd == 8'h00) begin
                    n_close++; close_cyc = cyc;
                end
            end
            nwr++;
        end
        if (bus_rd) begin
            if (!hv_en) v_hv++;
            if (a0_seen == 0 || cyc != a0_cyc + VCYC + 1 || int'(bus_addr) != a0_addr) v_r5++;
            a0_seen = 0;
            if (nrd == 0) begin
                if (bus_addr != 0) v_r6++;
            end else if (resume != 0) begin
                if (int'(bus_addr) != fail_addr) v_r7++;
            end else if (int'(bus_addr) != prev + 1) v_r6++;
            resume = 0; prev = int'(bus_addr); nrd++;
            if (erases >= need[bus_addr]) rd_data = 8'hFF;
            else begin
                rd_data = 8'h5A ^ {5'd0, bus_addr};
                fail_addr = int'(bus_addr);
            end
        end
        if (done || err) begin
            n_end++; got_err = err ? 1 : 0;
            if (hv_en) v_r9++;
            if (close_cyc != cyc - 1) v_r9++;
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run(input int exp_err, input int exp_pulses, input int exp_reads,
                       input bit poke);
        int saved_wr;
        clear_mon();
        pulse_start();
        for (int i = 0; i < 3000 && n_end == 0; i++) begin
            @(posedge clk);
            if (poke && (i == 6 || i == 25)) begin
                chk(busy === 1'b1, "R10 busy while running", int'(busy), 1);
                #1 start = 1'b1;
                @(posedge clk); #1 start = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        saved_wr = nwr;
        chk(n_end == 1, "R10 one end pulse", n_end, 1);
        chk(got_err == exp_err, "R8/R9 outcome err flag", got_err, exp_err);
        chk(erases == exp_pulses, "R8 erase pulse count", erases, exp_pulses);
        chk(nrd == exp_reads, "R7 verify read count", nrd, exp_reads);
        chk(n_close == 1, "R9 read-mode write count", n_close, 1);
        chk(v_hv == 0, "R2 strobe without hv_en", v_hv, 0);
        chk(v_r3 == 0, "R3 erase pair shape", v_r3, 0);
        chk(v_r4 == 0, "R4 erase wait length", v_r4, 0);
        chk(v_r5 == 0, "R5 verify timing/address", v_r5, 0);
        chk(v_r6 == 0, "R6 address order", v_r6, 0);
        chk(v_r7 == 0, "R7 resume address", v_r7, 0);
        chk(v_r9 == 0, "R9 end after close, hv low", v_r9, 0);
        if (poke) begin
            repeat (20) @(posedge clk);
            chk(nwr == saved_wr && n_end == 1 && !busy, "R10 start ignored while busy",
                nwr - saved_wr, 0);
        end
    endtask

    initial begin
        int ep, er, ee;
        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !hv_en && !bus_wr && !bus_rd && !done && !err,
            "R1 reset idle", int'({busy, hv_en, bus_wr, bus_rd, done, err}), 0);

        // Every byte erases on the first pulse.
        run(0, 1, DEPTH, 1'b0);

        // Several slow bytes: pulses 3, one extra read per re-erase.
        need[1] = 2; need[3] = 3; need[6] = 2;
        run(0, 3, DEPTH + 2, 1'b0);
        for (int i = 0; i < DEPTH; i++) need[i] = 1;

        // Start pokes while busy must not restart or extend the run.
        need[4] = 2;
        run(0, 2, DEPTH + 1, 1'b1);
        need[4] = 1;

        // Sweep: one slow byte at each address, needing 1..MAXP+1 pulses.
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 1; k <= MAXP + 1; k++) begin
                need[a] = k;
                if (k <= MAXP) begin ee = 0; ep = k; er = DEPTH + k - 1; end
                else begin ee = 1; ep = MAXP; er = a + MAXP; end
                run(ee, ep, er, 1'b0);
                need[a] = 1;
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule